// File: doc/BRIEF.md
# Registered Bus Width Exchanger

This block sits between one narrow word port (the A side) and a pair of narrow word ports (lane 1 and lane 2 of the B side). Together, the two B lanes form one word of twice the width. Going from A to B, two successive A words can be parked in separate lane registers. Each lane register has its own active-low load enable, so two words that arrive one after the other are presented side by side as one wide word. Going from B to A, a select input picks one of the lanes, and the picked word is stored in a single A-side register on every clock edge.

Every control input is sampled into a register before it acts. This covers the lane load enables, the lane select and the three active-low output enables. A change on a control therefore reaches the data path or the output drive one clock edge later. Each three-state port is modelled as an output data bus plus an active-high drive flag. An active-high synchronous reset clears all data registers. The same reset sets the captured controls to their idle values: no lane loads, lane 2 is selected and no port drives.

Internally, the captured lane enables set an enumerated capture state (CAP_HOLD, CAP_LANE1, CAP_LANE2, CAP_BOTH). The captured select sets a source state (SRC_LANE1, SRC_LANE2). The state is recomputed from the sampled controls on every clock edge, so every transition between states is direct. The reset returns the block to CAP_HOLD and SRC_LANE2.

Top module: `bus_width_exchanger`

## Requirements
- R1: While `rst` is high at a rising edge, every data output is cleared to zero after that edge and every drive flag is cleared to 0.
- R2: If `cken1_n` is sampled low at edge k, the lane 1 register takes the `a_in` value present at edge k+1, and `b1_out` shows that value after edge k+1.
- R3: If `cken2_n` is sampled low at edge k, the lane 2 register takes the `a_in` value present at edge k+1, and `b2_out` shows that value after edge k+1.
- R4: A lane whose enable was sampled high at edge k keeps its contents through edge k+1. With both enables high, neither B output changes, whatever `a_in` does.
- R5: If both enables are sampled low at edge k, both lanes load the same `a_in` value at edge k+1, so `b1_out` equals `b2_out`.
- R6: The A register loads on every edge after reset. The lane it loads from is set by `sel` as sampled at the previous edge: 1 takes `b1_in` and 0 takes `b2_in`.
- R7: Each drive flag (`a_drive`, `b1_drive`, `b2_drive`) equals the inverse of its active-low enable (`oe_a_n`, `oe_b1_n`, `oe_b2_n`) as sampled at the previous edge.
- R8: The data outputs show the register contents whether or not the port is driving. Turning a port's drive off and on again leaves its held value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 12 | Word arriving on the A side |
| cken1_n | input | 1 | Lane 1 load enable, active low, registered |
| cken2_n | input | 1 | Lane 2 load enable, active low, registered |
| sel | input | 1 | Return-path lane select (1 = lane 1, 0 = lane 2), registered |
| oe_a_n | input | 1 | A port output enable, active low, registered |
| oe_b1_n | input | 1 | Lane 1 output enable, active low, registered |
| oe_b2_n | input | 1 | Lane 2 output enable, active low, registered |
| b1_in | input | 12 | Word arriving on lane 1 |
| b2_in | input | 12 | Word arriving on lane 2 |
| a_out | output | 12 | A-side register contents |
| a_drive | output | 1 | A port drive flag |
| b1_out | output | 12 | Lane 1 register contents |
| b1_drive | output | 1 | Lane 1 drive flag |
| b2_out | output | 12 | Lane 2 register contents |
| b2_drive | output | 1 | Lane 2 drive flag |

## Verification
A wrong capture state shows up exactly two edges after the control is applied. In that case a lane either takes a word it should have held, or holds a word it should have taken, and `b1_out` or `b2_out` stays wrong until that lane is next loaded. A wrong source state corrupts `a_out` two edges after the select changes. The error lasts only one cycle, because the A register reloads on every edge. A drive flag with the wrong latency or polarity shows one edge after the enable changes.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

    localparam int LANES = 2;

    // Capture state set by the two sampled lane enables.
    typedef enum logic [1:0] {
        CAP_HOLD  = 2'd0,
        CAP_LANE1 = 2'd1,
        CAP_LANE2 = 2'd2,
        CAP_BOTH  = 2'd3
    } cap_state_t;

    // Source state of the return path.
    typedef enum logic {
        SRC_LANE2 = 1'b0,
        SRC_LANE1 = 1'b1
    } src_state_t;

    // Index of each port in the registered drive vector.
    localparam int DRV_A  = 0;
    localparam int DRV_B1 = 1;
    localparam int DRV_B2 = 2;
    localparam int DRV_N  = LANES + 1;

endpackage

// File: rtl/xchg_ctrl.sv
module xchg_ctrl
    import xchg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cken1_n,
    input  logic                    cken2_n,
    input  logic                    sel,
    input  logic [DRV_N-1:0]        oe_n,
    output logic [LANES-1:0]        lane_load,
    output logic                    take_lane1,
    output logic [DRV_N-1:0]        drive
);

    cap_state_t cap_q, cap_d;
    src_state_t src_q, src_d;
    logic [DRV_N-1:0] oe_n_q;

    // Next-state selection from the raw control inputs.
    always_comb begin
        unique case ({~cken2_n, ~cken1_n})
            2'b00:   cap_d = CAP_HOLD;
            2'b01:   cap_d = CAP_LANE1;
            2'b10:   cap_d = CAP_LANE2;
            default: cap_d = CAP_BOTH;
        endcase
        src_d = sel ? SRC_LANE1 : SRC_LANE2;
    end

    // State register for the controls.
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= CAP_HOLD;
            src_q  <= SRC_LANE2;
            oe_n_q <= '1;
        end else begin
            cap_q  <= cap_d;
            src_q  <= src_d;
            oe_n_q <= oe_n;
        end
    end

    // Decode of the state into data-path strobes.
    always_comb begin
        unique case (cap_q)
            CAP_HOLD:  lane_load = 2'b00;
            CAP_LANE1: lane_load = 2'b01;
            CAP_LANE2: lane_load = 2'b10;
            CAP_BOTH:  lane_load = 2'b11;
            default:   lane_load = 2'b00;
        endcase
        unique case (src_q)
            SRC_LANE1: take_lane1 = 1'b1;
            SRC_LANE2: take_lane1 = 1'b0;
            default:   take_lane1 = 1'b0;
        endcase
        drive = ~oe_n_q;
    end

endmodule

// File: rtl/xchg_lane.sv
module xchg_lane #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end

endmodule

// File: rtl/xchg_return.sv
module xchg_return #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_lane1,
    input  logic [WORD_W-1:0] lane1,
    input  logic [WORD_W-1:0] lane2,
    output logic [WORD_W-1:0] q
);

    logic [WORD_W-1:0] pick;

    always_comb pick = take_lane1 ? lane1 : lane2;

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= pick;
    end

endmodule

// File: rtl/bus_width_exchanger.sv
module bus_width_exchanger
    import xchg_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] a_in,
    input  logic              cken1_n,
    input  logic              cken2_n,
    input  logic              sel,
    input  logic              oe_a_n,
    input  logic              oe_b1_n,
    input  logic              oe_b2_n,
    input  logic [WORD_W-1:0] b1_in,
    input  logic [WORD_W-1:0] b2_in,
    output logic [WORD_W-1:0] a_out,
    output logic              a_drive,
    output logic [WORD_W-1:0] b1_out,
    output logic              b1_drive,
    output logic [WORD_W-1:0] b2_out,
    output logic              b2_drive
);

    logic [LANES-1:0]  lane_load;
    logic              take_lane1;
    logic [DRV_N-1:0]  oe_n_vec;
    logic [DRV_N-1:0]  drive_vec;
    logic [WORD_W-1:0] lane_q [LANES];

    always_comb begin
        oe_n_vec[DRV_A]  = oe_a_n;
        oe_n_vec[DRV_B1] = oe_b1_n;
        oe_n_vec[DRV_B2] = oe_b2_n;
    end

    xchg_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cken1_n    (cken1_n),
        .cken2_n    (cken2_n),
        .sel        (sel),
        .oe_n       (oe_n_vec),
        .lane_load  (lane_load),
        .take_lane1 (take_lane1),
        .drive      (drive_vec)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        xchg_lane #(.WORD_W(WORD_W)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .load (lane_load[g]),
            .d    (a_in),
            .q    (lane_q[g])
        );
    end

    xchg_return #(.WORD_W(WORD_W)) u_ret (
        .clk        (clk),
        .rst        (rst),
        .take_lane1 (take_lane1),
        .lane1      (b1_in),
        .lane2      (b2_in),
        .q          (a_out)
    );

    always_comb begin
        b1_out   = lane_q[0];
        b2_out   = lane_q[1];
        a_drive  = drive_vec[DRV_A];
        b1_drive = drive_vec[DRV_B1];
        b2_drive = drive_vec[DRV_B2];
    end

endmodule

// File: rtl/bus_width_exchanger_chk.sv
module bus_width_exchanger_chk #(
    parameter int WORD_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] a_in,
    input logic              cken1_n,
    input logic              cken2_n,
    input logic              sel,
    input logic              oe_a_n,
    input logic              oe_b1_n,
    input logic              oe_b2_n,
    input logic [WORD_W-1:0] b1_in,
    input logic [WORD_W-1:0] b2_in,
    input logic [WORD_W-1:0] a_out,
    input logic              a_drive,
    input logic [WORD_W-1:0] b1_out,
    input logic              b1_drive,
    input logic [WORD_W-1:0] b2_out,
    input logic              b2_drive
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= 2'd0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (a_out == '0 && b1_out == '0 && b2_out == '0 &&
                        !a_drive && !b1_drive && !b2_drive));

    // R2
    lane1_load_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && !$past(cken1_n, 2)) |-> b1_out == $past(a_in));

    // R3
    lane2_load_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && !$past(cken2_n, 2)) |-> b2_out == $past(a_in));

    // R4
    lane1_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && $past(cken1_n, 2)) |-> $stable(b1_out));

    // R4
    lane2_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && $past(cken2_n, 2)) |-> $stable(b2_out));

    // R5
    dual_load_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && !$past(cken1_n, 2) && !$past(cken2_n, 2))
            |-> b1_out == b2_out);

    // R6
    return_path_chk: assert property (@(posedge clk) disable iff (rst)
        since_rst >= 2'd2 |->
            a_out == ($past(sel, 2) ? $past(b1_in) : $past(b2_in)));

    // R7
    drive_latency_chk: assert property (@(posedge clk) disable iff (rst)
        since_rst >= 2'd1 |-> (a_drive == !$past(oe_a_n) &&
                               b1_drive == !$past(oe_b1_n) &&
                               b2_drive == !$past(oe_b2_n)));

endmodule

bind bus_width_exchanger bus_width_exchanger_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/bus_width_exchanger_tb_top.sv
module bus_width_exchanger_tb_top;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic         cken1_n = 1'b1, cken2_n = 1'b1, sel = 1'b0;
    logic         oe_a_n = 1'b1, oe_b1_n = 1'b1, oe_b2_n = 1'b1;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_drive, b1_drive, b2_drive;

    always #5 clk = ~clk;

    bus_width_exchanger #(.WORD_W(W)) dut_i (
        .clk(clk), .rst(rst), .a_in(a_in), .cken1_n(cken1_n), .cken2_n(cken2_n),
        .sel(sel), .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n),
        .b1_in(b1_in), .b2_in(b2_in), .a_out(a_out), .a_drive(a_drive),
        .b1_out(b1_out), .b1_drive(b1_drive), .b2_out(b2_out), .b2_drive(b2_drive)
    );

    typedef struct {
        string        tag;
        logic [W-1:0] a, b1, b2;
        logic         da, d1, d2;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;

    // Next stimulus, applied by tick at a falling edge.
    logic         n_rst = 1'b1;
    logic [W-1:0] n_a = '0, n_b1 = '0, n_b2 = '0;
    logic         n_c1 = 1'b1, n_c2 = 1'b1, n_sel = 1'b0;
    logic         n_oa = 1'b1, n_o1 = 1'b1, n_o2 = 1'b1;

    // Reference state built from the requirements.
    logic [W-1:0] m_a = '0, m_b1 = '0, m_b2 = '0;
    logic         m_c1 = 1'b1, m_c2 = 1'b1, m_sel = 1'b0;
    logic         m_oa = 1'b1, m_o1 = 1'b1, m_o2 = 1'b1;

    task automatic tick(input string tag);
        exp_t e;
        @(negedge clk);
        rst = n_rst; a_in = n_a; b1_in = n_b1; b2_in = n_b2;
        cken1_n = n_c1; cken2_n = n_c2; sel = n_sel;
        oe_a_n = n_oa; oe_b1_n = n_o1; oe_b2_n = n_o2;
        if (n_rst) begin
            m_a = '0; m_b1 = '0; m_b2 = '0;
            m_c1 = 1'b1; m_c2 = 1'b1; m_sel = 1'b0;
            m_oa = 1'b1; m_o1 = 1'b1; m_o2 = 1'b1;
        end else begin
            if (!m_c1) m_b1 = n_a;
            if (!m_c2) m_b2 = n_a;
            m_a  = m_sel ? n_b1 : n_b2;
            m_c1 = n_c1; m_c2 = n_c2; m_sel = n_sel;
            m_oa = n_oa; m_o1 = n_o1; m_o2 = n_o2;
        end
        e.tag = tag; e.a = m_a; e.b1 = m_b1; e.b2 = m_b2;
        e.da = !m_oa; e.d1 = !m_o1; e.d2 = !m_o2;
        q.push_back(e);
    endtask

    task automatic cmp(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: compares each expected item just after its edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, "a_out", a_out, e.a);
                cmp(e.tag, "b1_out", b1_out, e.b1);
                cmp(e.tag, "b2_out", b2_out, e.b2);
                cmp(e.tag, "a_drive", {{(W-1){1'b0}}, a_drive}, {{(W-1){1'b0}}, e.da});
                cmp(e.tag, "b1_drive", {{(W-1){1'b0}}, b1_drive}, {{(W-1){1'b0}}, e.d1});
                cmp(e.tag, "b2_drive", {{(W-1){1'b0}}, b2_drive}, {{(W-1){1'b0}}, e.d2});
            end
        end
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) tick("R1");
        n_rst = 1'b0;
        n_b1 = 12'h5A5; n_b2 = 12'h3C3;
        tick("R1");
        // R7: enable all drives, visible one edge later
        n_oa = 1'b0; n_o1 = 1'b0; n_o2 = 1'b0;
        tick("R7");
        tick("R7");
        // R2: lane 1 load with one-cycle control latency
        n_c1 = 1'b0; n_a = 12'h0F0;
        tick("R2");
        n_c1 = 1'b1; n_a = 12'h111;
        tick("R2");
        n_a = 12'h999;
        tick("R2");
        // R3: lane 2 load
        n_c2 = 1'b0; n_a = 12'h777;
        tick("R3");
        n_c2 = 1'b1; n_a = 12'h222;
        tick("R3");
        // R4: both enables high, a_in moving
        for (int i = 0; i < 5; i++) begin
            n_a = 12'(12'h800 + i * 37);
            tick("R4");
        end
        // R5: both lanes load together
        n_c1 = 1'b0; n_c2 = 1'b0; n_a = 12'h123;
        tick("R5");
        n_c1 = 1'b1; n_c2 = 1'b1; n_a = 12'hABC;
        tick("R5");
        tick("R5");
        // R2 and R3: back-to-back words into alternate lanes
        n_c1 = 1'b0; n_a = 12'h321;
        tick("R2");
        n_c1 = 1'b1; n_c2 = 1'b0; n_a = 12'h654;
        tick("R3");
        n_c2 = 1'b1; n_a = 12'hFED;
        tick("R3");
        tick("R2");
        // R6: return path, select toggling with changing lane inputs
        for (int i = 0; i < 8; i++) begin
            n_sel = i[0];
            n_b1 = 12'(12'h100 + i);
            n_b2 = 12'(12'hE00 + i * 3);
            tick("R6");
        end
        n_sel = 1'b1;
        tick("R6");
        tick("R6");
        // R8: drive off and on, held values unchanged
        n_oa = 1'b1; n_o1 = 1'b1; n_o2 = 1'b1;
        tick("R8");
        n_o1 = 1'b0;
        tick("R8");
        n_oa = 1'b0; n_o2 = 1'b0;
        tick("R8");
        // R7: mixed drive patterns
        n_oa = 1'b1; n_o1 = 1'b0; n_o2 = 1'b1;
        tick("R7");
        n_oa = 1'b0; n_o1 = 1'b1; n_o2 = 1'b0;
        tick("R7");
        // R1: reset mid-run
        n_rst = 1'b1;
        tick("R1");
        n_rst = 1'b0;
        tick("R1");
        tick("R1");
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule